// File: doc/BRIEF.md
# I2C Slave Protocol Engine with Live State Word

This block is the target side of a two-wire serial bus. It watches clock and data lines that have already been synchronized to the system clock and picks out START, repeated START and STOP conditions. After a START it takes in an address byte and compares it with a programmed address. In 10-bit mode it takes two address bytes. It acknowledges a match and then either receives data bytes into a byte output or sends bytes taken from a byte input. The engine pulls SDA low itself for its own acknowledges and for the zero bits it sends.

Software sees the engine through two byte streams and one 8-bit state word. The receive side gives each byte with a one-cycle `rx_valid` pulse; `rx_ready` says whether the consumer can take it. The transmit side loads each byte with a `tx_valid`/`tx_ready` handshake. The state word can be read at any time. Its upper nibble is the main state and its lower nibble is the bit position inside the current byte.

Main states and their transitions:
- Idle (0x0): goes to Slave Start on START.
- Slave Start (0x1): goes to Receive Addr1 when SCL falls.
- Receive Addr1 (0xA): goes to Receive Addr2, Transmit Data or Receive Data on an accepted byte, and to Bystander on a rejected one.
- Receive Addr2 (0xB): goes to Receive Data on a match and to Bystander otherwise.
- Receive Data (0x9): loops back to itself after each acknowledged byte, or goes to Slave Wait after its own NACK.
- Transmit Data (0x8): loops back to itself when the master acknowledges, or goes to Slave Wait when the master NACKs.
- Bystander (0x2) and Slave Wait (0x3): left only on START or STOP.

From any state, STOP leads to Idle and START leads to Slave Start.

Top module: `i2c_slave_diag`

## Requirements
- R1: After reset the state word is 0x00, SDA is released and both byte strobes are low. While `enable` is low the engine is in Idle (0x00) from the next cycle on, and SDA is released.
- R2: A START or repeated START (SDA falling while SCL stays high) puts the engine in Slave Start (0x1) from any state. A STOP (SDA rising while SCL stays high) puts it in Idle (0x0) from any state.
- R3: The upper state nibble only ever holds one of the codes 0x0, 0x1, 0x2, 0x3, 0x8, 0x9, 0xA or 0xB.
- R4: In the address and data states the lower nibble counts the bits of the byte MSB first: 0 is the first bit and 7 the last. It advances on each SCL fall, and 8 marks the acknowledge slot. In all other states the lower nibble is 0.
- R5: In 7-bit mode (`ten_bit_mode`=0) the first byte is accepted when bits 7:1 equal `own_addr[6:0]`. The engine acknowledges it, and bit 0 picks Transmit Data (1) or Receive Data (0).
- R6: In 10-bit mode a first byte of 11110, then `own_addr[9:8]`, then bit 0 = 0 is acknowledged and leads to Receive Addr2. A second byte equal to `own_addr[7:0]` is acknowledged and leads to Receive Data.
- R7: In 10-bit mode a first byte of 11110, then `own_addr[9:8]`, then bit 0 = 1 is acknowledged only if a full 10-bit write address has matched since the last STOP. It then leads to Transmit Data; without that earlier match it is rejected.
- R8: A rejected address byte is not acknowledged and puts the engine in Bystander (0x2). Bytes that follow get no acknowledge until the next START or STOP.
- R9: A received data byte is presented on `rx_data` with a one-cycle `rx_valid` and acknowledged when `rx_ready` is high at the end of the byte. If `rx_ready` is low, the byte is not acknowledged, not presented, and the engine goes to Slave Wait (0x3).
- R10: At the start of every transmitted byte the engine raises `tx_ready` for one cycle and loads `tx_data`, or 0xFF if `tx_valid` is low. It then sends that byte MSB first.
- R11: After a transmitted byte, a master ACK (SDA low) starts the next byte. A master NACK puts the engine in Slave Wait (0x3).
- R12: In Slave Wait the engine drives nothing and presents no bytes until a START or STOP.
- R13: SDA is pulled low only while SCL is low at the moment it starts or stops being pulled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Engine enable; low forces Idle |
| ten_bit_mode | input | 1 | 1 selects two-byte 10-bit addressing |
| own_addr | input | 10 | Programmed address (7-bit mode uses bits 6:0) |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| sda_pull_low | output | 1 | 1 pulls the SDA line low |
| tx_data | input | 8 | Next byte to send |
| tx_valid | input | 1 | `tx_data` holds a byte |
| tx_ready | output | 1 | One-cycle strobe: byte taken from `tx_data` |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` is new |
| rx_ready | input | 1 | Consumer can take a byte |
| diag_state | output | 8 | Live state word: {main state, bit substate} |

## Verification
Some rules are checked by assertions on every cycle:
- the upper nibble holds only legal codes, and the substate stays in range and is zero outside the bit-carrying states;
- START, STOP and a low `enable` lead to Slave Start or Idle one cycle later;
- `rx_valid` and `tx_ready` last one cycle, and `tx_ready` is followed by Transmit Data at bit 0;
- SDA starts and stops being pulled only while SCL is low.

Other behaviour only the bench scenarios can show. These are the address decisions (7-bit, two-byte 10-bit, the 10-bit read that needs an earlier write match, and the rejected patterns), the exact substate values at given bit counts, and the bytes sent and received. They also include the NACK paths into Slave Wait and how Bystander and Slave Wait ignore later bytes.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int BYTE_W  = 8;
    localparam int STATE_W = 4;
    localparam int SUB_W   = 4;
    localparam int ADDR_W  = 10;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE    = 4'h0,
        ST_START   = 4'h1,
        ST_BYSTAND = 4'h2,
        ST_WAIT    = 4'h3,
        ST_TX      = 4'h8,
        ST_RX      = 4'h9,
        ST_ADR1    = 4'hA,
        ST_ADR2    = 4'hB
    } main_e;

    localparam logic [SUB_W-1:0] SUB_ACK  = SUB_W'(BYTE_W);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(BYTE_W - 1);
    localparam logic [4:0]       TEN_HDR  = 5'b11110;
endpackage

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign scl_rise  = scl & ~scl_q;
    assign scl_fall  = ~scl & scl_q;
    assign start_evt = scl & scl_q & sda_q & ~sda;
    assign stop_evt  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match #(
    parameter int ADDR_W = i2cs_pkg::ADDR_W,
    parameter int BYTE_W = i2cs_pkg::BYTE_W
) (
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_mode,
    input  logic              ten_done,
    output logic              hdr_ok,
    output logic              low_ok
);
    import i2cs_pkg::*;

    localparam int HI_W = ADDR_W - BYTE_W;

    logic seven_ok;
    logic ten_hdr_ok;

    assign seven_ok   = (byte_in[BYTE_W-1:1] == own_addr[BYTE_W-2:0]);
    assign ten_hdr_ok = (byte_in[BYTE_W-1 -: 5] == TEN_HDR)
                      && (byte_in[HI_W:1] == own_addr[ADDR_W-1 -: HI_W])
                      && (!byte_in[0] || ten_done);
    assign hdr_ok     = ten_mode ? ten_hdr_ok : seven_ok;
    assign low_ok     = (byte_in == own_addr[BYTE_W-1:0]);
endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm #(
    parameter int BYTE_W  = i2cs_pkg::BYTE_W,
    parameter int STATE_W = i2cs_pkg::STATE_W,
    parameter int SUB_W   = i2cs_pkg::SUB_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic                       ten_mode,
    input  logic                       scl_rise,
    input  logic                       scl_fall,
    input  logic                       start_evt,
    input  logic                       stop_evt,
    input  logic                       sda_smp,
    input  logic                       hdr_ok,
    input  logic                       low_ok,
    output logic                       ten_done,
    output logic [BYTE_W-1:0]          shift_byte,
    input  logic [BYTE_W-1:0]          tx_data,
    input  logic                       tx_valid,
    output logic                       tx_ready,
    output logic [BYTE_W-1:0]          rx_data,
    output logic                       rx_valid,
    input  logic                       rx_ready,
    output logic                       sda_pull_low,
    output logic [STATE_W+SUB_W-1:0]   diag
);
    import i2cs_pkg::*;

    main_e             state_q, state_d;
    logic [SUB_W-1:0]  sub_q, sub_d;
    logic [BYTE_W-1:0] rx_sh_q;
    logic [BYTE_W-1:0] tx_sh_q;
    logic [BYTE_W-1:0] rx_data_q;
    logic              rx_valid_q;
    logic              rw_q;
    logic              ten_done_q;
    logic              mack_n_q;
    logic              load_tx;
    logic              byte_end;
    logic              ack_fall;
    logic              bit_state;

    assign byte_end  = scl_fall && (sub_q == SUB_LAST);
    assign ack_fall  = scl_fall && (sub_q == SUB_ACK);
    assign bit_state = (state_q == ST_ADR1) || (state_q == ST_ADR2) || (state_q == ST_RX);

    // next-state logic
    always_comb begin
        state_d = state_q;
        sub_d   = sub_q;
        load_tx = 1'b0;
        if (!enable) begin
            state_d = ST_IDLE;
            sub_d   = '0;
        end else if (stop_evt) begin
            state_d = ST_IDLE;
            sub_d   = '0;
        end else if (start_evt) begin
            state_d = ST_START;
            sub_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_BYSTAND, ST_WAIT: begin
                    sub_d = '0;
                end
                ST_START: begin
                    if (scl_fall) begin
                        state_d = ST_ADR1;
                        sub_d   = '0;
                    end
                end
                ST_ADR1: begin
                    if (byte_end) begin
                        if (hdr_ok) begin
                            sub_d = SUB_ACK;
                        end else begin
                            state_d = ST_BYSTAND;
                            sub_d   = '0;
                        end
                    end else if (ack_fall) begin
                        sub_d = '0;
                        if (ten_mode && !rw_q) begin
                            state_d = ST_ADR2;
                        end else if (rw_q) begin
                            state_d = ST_TX;
                            load_tx = 1'b1;
                        end else begin
                            state_d = ST_RX;
                        end
                    end else if (scl_fall) begin
                        sub_d = sub_q + SUB_W'(1);
                    end
                end
                ST_ADR2: begin
                    if (byte_end) begin
                        if (low_ok) begin
                            sub_d = SUB_ACK;
                        end else begin
                            state_d = ST_BYSTAND;
                            sub_d   = '0;
                        end
                    end else if (ack_fall) begin
                        state_d = ST_RX;
                        sub_d   = '0;
                    end else if (scl_fall) begin
                        sub_d = sub_q + SUB_W'(1);
                    end
                end
                ST_RX: begin
                    if (byte_end) begin
                        if (rx_ready) begin
                            sub_d = SUB_ACK;
                        end else begin
                            state_d = ST_WAIT;
                            sub_d   = '0;
                        end
                    end else if (ack_fall) begin
                        sub_d = '0;
                    end else if (scl_fall) begin
                        sub_d = sub_q + SUB_W'(1);
                    end
                end
                ST_TX: begin
                    if (ack_fall) begin
                        if (!mack_n_q) begin
                            sub_d   = '0;
                            load_tx = 1'b1;
                        end else begin
                            state_d = ST_WAIT;
                            sub_d   = '0;
                        end
                    end else if (scl_fall) begin
                        sub_d = sub_q + SUB_W'(1);
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    sub_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sub_q   <= '0;
        end else begin
            state_q <= state_d;
            sub_q   <= sub_d;
        end
    end

    // byte datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh_q    <= '0;
            tx_sh_q    <= '1;
            rx_data_q  <= '0;
            rx_valid_q <= 1'b0;
            rw_q       <= 1'b0;
            ten_done_q <= 1'b0;
            mack_n_q   <= 1'b1;
        end else begin
            rx_valid_q <= 1'b0;
            if (scl_rise && bit_state && (sub_q != SUB_ACK)) begin
                rx_sh_q <= {rx_sh_q[BYTE_W-2:0], sda_smp};
            end
            if (scl_rise && (state_q == ST_TX) && (sub_q == SUB_ACK)) begin
                mack_n_q <= sda_smp;
            end
            if (enable && (state_q == ST_ADR1) && byte_end) begin
                rw_q       <= rx_sh_q[0];
                ten_done_q <= ten_mode && hdr_ok && rx_sh_q[0] && ten_done_q;
            end
            if (enable && (state_q == ST_ADR2) && byte_end && low_ok) begin
                ten_done_q <= 1'b1;
            end
            if (enable && (state_q == ST_RX) && byte_end && rx_ready) begin
                rx_valid_q <= 1'b1;
                rx_data_q  <= rx_sh_q;
            end
            if (load_tx) begin
                tx_sh_q <= tx_valid ? tx_data : '1;
            end else if ((state_q == ST_TX) && scl_fall && (sub_q < SUB_LAST)) begin
                tx_sh_q <= {tx_sh_q[BYTE_W-2:0], 1'b1};
            end
            if (!enable || stop_evt) begin
                ten_done_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ADR1, ST_ADR2, ST_RX: sda_pull_low = (sub_q == SUB_ACK);
            ST_TX:                   sda_pull_low = (sub_q != SUB_ACK) && !tx_sh_q[BYTE_W-1];
            default:                 sda_pull_low = 1'b0;
        endcase
    end

    assign diag       = {state_q, sub_q};
    assign tx_ready   = load_tx;
    assign rx_data    = rx_data_q;
    assign rx_valid   = rx_valid_q;
    assign ten_done   = ten_done_q;
    assign shift_byte = rx_sh_q;

    // R3
    main_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q inside {ST_IDLE, ST_START, ST_BYSTAND, ST_WAIT, ST_TX, ST_RX, ST_ADR1, ST_ADR2});

    // R4
    sub_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sub_q <= SUB_ACK);

    // R4
    sub_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_IDLE, ST_START, ST_BYSTAND, ST_WAIT}) |-> (sub_q == '0));

    // R2
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && stop_evt) |=> (state_q == ST_IDLE));

    // R2
    start_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start_evt) |=> (state_q == ST_START));

    // R1
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_q == ST_IDLE) && !sda_pull_low);

    // R9
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_q |=> !rx_valid_q);

    // R10
    tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> (state_q == ST_TX) && (sub_q == '0) && !tx_ready);
endmodule

// File: rtl/i2c_slave_diag.sv
module i2c_slave_diag #(
    parameter int ADDR_W  = i2cs_pkg::ADDR_W,
    parameter int BYTE_W  = i2cs_pkg::BYTE_W,
    parameter int STATE_W = i2cs_pkg::STATE_W,
    parameter int SUB_W   = i2cs_pkg::SUB_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     ten_bit_mode,
    input  logic [ADDR_W-1:0]        own_addr,
    input  logic                     scl_in,
    input  logic                     sda_in,
    output logic                     sda_pull_low,
    input  logic [BYTE_W-1:0]        tx_data,
    input  logic                     tx_valid,
    output logic                     tx_ready,
    output logic [BYTE_W-1:0]        rx_data,
    output logic                     rx_valid,
    input  logic                     rx_ready,
    output logic [STATE_W+SUB_W-1:0] diag_state
);
    logic              scl_rise;
    logic              scl_fall;
    logic              start_evt;
    logic              stop_evt;
    logic              hdr_ok;
    logic              low_ok;
    logic              ten_done;
    logic [BYTE_W-1:0] shift_byte;

    i2cs_bus_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (scl_in),
        .sda       (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2cs_addr_match #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W)
    ) u_match (
        .byte_in  (shift_byte),
        .own_addr (own_addr),
        .ten_mode (ten_bit_mode),
        .ten_done (ten_done),
        .hdr_ok   (hdr_ok),
        .low_ok   (low_ok)
    );

    i2cs_fsm #(
        .BYTE_W  (BYTE_W),
        .STATE_W (STATE_W),
        .SUB_W   (SUB_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .ten_mode     (ten_bit_mode),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_evt    (start_evt),
        .stop_evt     (stop_evt),
        .sda_smp      (sda_in),
        .hdr_ok       (hdr_ok),
        .low_ok       (low_ok),
        .ten_done     (ten_done),
        .shift_byte   (shift_byte),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_ready     (rx_ready),
        .sda_pull_low (sda_pull_low),
        .diag         (diag_state)
    );

    // R13
    pull_start_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        $rose(sda_pull_low) |-> !scl_in);

    // R13
    pull_release_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        $fell(sda_pull_low) |-> !scl_in);
endmodule

// File: tb/test_i2c_slave_diag.sv
module test_i2c_slave_diag;
    localparam int HALF = 4;
    localparam logic [9:0] OWN = 10'h1A5;

    typedef struct packed {
        logic       ten;
        logic [7:0] b0;
        logic [7:0] b1;
        logic       ack0;
        logic       ack1;
        logic [3:0] fin;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b0, 8'h4A, 8'h00, 1'b1, 1'b0, 4'h9},
        '{1'b0, 8'h4B, 8'h00, 1'b1, 1'b0, 4'h8},
        '{1'b0, 8'h4C, 8'h00, 1'b0, 1'b0, 4'h2},
        '{1'b1, 8'hF2, 8'hA5, 1'b1, 1'b1, 4'h9},
        '{1'b1, 8'hF2, 8'hA4, 1'b1, 1'b0, 4'h2},
        '{1'b1, 8'hF0, 8'h00, 1'b0, 1'b0, 4'h2},
        '{1'b1, 8'h4A, 8'h00, 1'b0, 1'b0, 4'h2},
        '{1'b1, 8'hF3, 8'h00, 1'b0, 1'b0, 4'h2},
        '{1'b0, 8'hF2, 8'h00, 1'b0, 1'b0, 4'h2}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       ten_bit_mode = 1'b0;
    logic       scl = 1'b1;
    logic       msda = 1'b1;
    logic       sda_bus;
    logic       sda_pull_low;
    logic [7:0] tx_data = 8'hFF;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b1;
    logic [7:0] diag_state;

    int checks = 0;
    int fails = 0;
    int rx_cnt = 0;
    int tx_cnt = 0;
    logic [7:0] rx_last = 8'h00;

    always #5 clk = ~clk;

    assign sda_bus = msda & ~sda_pull_low;

    i2c_slave_diag i_i2c_slave_diag (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .ten_bit_mode (ten_bit_mode),
        .own_addr     (OWN),
        .scl_in       (scl),
        .sda_in       (sda_bus),
        .sda_pull_low (sda_pull_low),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_ready     (rx_ready),
        .diag_state   (diag_state)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt  <= rx_cnt + 1;
            rx_last <= rx_data;
        end
    end

    always @(posedge clk) begin
        if (tx_valid && tx_ready) tx_cnt <= tx_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        msda = 1'b1; wclk(HALF);
        scl  = 1'b1; wclk(HALF);
        msda = 1'b0; wclk(HALF);
        scl  = 1'b0; wclk(HALF);
    endtask

    task automatic bus_stop();
        msda = 1'b0; wclk(HALF);
        scl  = 1'b1; wclk(HALF);
        msda = 1'b1; wclk(HALF);
    endtask

    task automatic send_bit(input logic b);
        msda = b;    wclk(HALF);
        scl  = 1'b1; wclk(HALF);
        scl  = 1'b0; wclk(HALF);
    endtask

    task automatic recv_bit(output logic b);
        msda = 1'b1; wclk(HALF);
        scl  = 1'b1; wclk(2);
        b = sda_bus; wclk(2);
        scl  = 1'b0; wclk(HALF);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic read_byte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
    endtask

    task automatic get_ack(output logic a);
        logic b;
        recv_bit(b);
        a = !b;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic       a;
        logic [7:0] rb;
        int         base;
        vec_t       v;

        wclk(3);
        // R1 reset state
        chk("R1 reset diag", diag_state, 8'h00);
        chk("R1 reset sda", sda_pull_low, 1'b0);
        chk("R1 reset strobes", {rx_valid, tx_ready}, 2'b00);
        rst_n  = 1'b1;
        wclk(2);
        enable = 1'b1;
        wclk(2);

        // table of address-phase vectors (R5 R6 R7 R8)
        for (int k = 0; k < 9; k++) begin
            v = VECS[k];
            ten_bit_mode = v.ten;
            bus_start();
            send_byte(v.b0);
            get_ack(a);
            chk($sformatf("R5 R6 R8 vec%0d first ack", k), a, v.ack0);
            if (v.ack0 && v.ten && !v.b0[0]) begin
                send_byte(v.b1);
                get_ack(a);
                chk($sformatf("R6 R8 vec%0d second ack", k), a, v.ack1);
            end
            chk($sformatf("R3 R5 R6 R8 vec%0d state", k), diag_state[7:4], v.fin);
            bus_stop();
            chk($sformatf("R2 vec%0d stop idle", k), diag_state, 8'h00);
        end

        // R2 R4 substate walk, 7-bit
        ten_bit_mode = 1'b0;
        msda = 1'b1; scl = 1'b1; wclk(HALF);
        msda = 1'b0; wclk(HALF);
        chk("R2 slave start", diag_state, 8'h10);
        scl = 1'b0; wclk(HALF);
        chk("R4 addr bit0", diag_state, 8'hA0);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        chk("R4 addr bit3", diag_state, 8'hA3);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        chk("R4 addr ack slot", diag_state, 8'hA8);
        chk("R5 ack driven", sda_pull_low, 1'b1);
        get_ack(a);
        chk("R5 rx entered", diag_state, 8'h90);

        // R9 receive with consumer ready, then not ready
        rx_ready = 1'b1;
        base = rx_cnt;
        send_byte(8'h3C);
        chk("R4 R9 data ack slot", diag_state, 8'h98);
        get_ack(a);
        chk("R9 data acked", a, 1'b1);
        chk("R9 byte count", rx_cnt - base, 1);
        chk("R9 byte value", rx_last, 8'h3C);
        rx_ready = 1'b0;
        send_byte(8'hA7);
        get_ack(a);
        chk("R9 nack when not ready", a, 1'b0);
        chk("R9 wait state", diag_state, 8'h30);
        send_byte(8'h4A);
        get_ack(a);
        chk("R12 wait ignores byte", {a, diag_state}, {1'b0, 8'h30});
        chk("R12 wait presents nothing", rx_cnt - base, 1);
        rx_ready = 1'b1;
        bus_start();
        chk("R2 repeated start to addr1", diag_state, 8'hA0);
        send_byte(8'h4C);
        get_ack(a);
        chk("R8 mismatch no ack", a, 1'b0);
        send_byte(8'h4A);
        get_ack(a);
        chk("R8 bystander ignores", {a, diag_state}, {1'b0, 8'h20});
        bus_stop();
        chk("R2 stop to idle", diag_state, 8'h00);

        // R10 R11 transmit
        tx_data = 8'hC5; tx_valid = 1'b1;
        base = tx_cnt;
        bus_start();
        send_byte(8'h4B);
        get_ack(a);
        chk("R5 read ack", a, 1'b1);
        chk("R5 tx entered", diag_state, 8'h80);
        read_byte(rb);
        chk("R10 tx byte", rb, 8'hC5);
        chk("R4 tx ack slot", diag_state, 8'h88);
        send_bit(1'b0);
        chk("R11 next byte loaded", tx_cnt - base, 2);
        read_byte(rb);
        chk("R11 second byte", rb, 8'hC5);
        send_bit(1'b1);
        chk("R11 master nack wait", diag_state, 8'h30);
        bus_stop();
        tx_valid = 1'b0;
        bus_start();
        send_byte(8'h4B);
        get_ack(a);
        read_byte(rb);
        chk("R10 no valid sends ff", rb, 8'hFF);
        send_bit(1'b1);
        bus_stop();

        // R7 10-bit read after write addressing
        ten_bit_mode = 1'b1;
        tx_data = 8'h96; tx_valid = 1'b1;
        bus_start();
        send_byte(8'hF2); get_ack(a);
        send_byte(8'hA5); get_ack(a);
        chk("R6 10-bit write rx", {a, diag_state}, {1'b1, 8'h90});
        bus_start();
        send_byte(8'hF3); get_ack(a);
        chk("R7 read header acked", a, 1'b1);
        chk("R7 tx entered", diag_state, 8'h80);
        read_byte(rb);
        chk("R7 R10 tx byte", rb, 8'h96);
        send_bit(1'b1);
        bus_stop();
        bus_start();
        send_byte(8'hF3); get_ack(a);
        chk("R7 read header after stop", {a, diag_state}, {1'b0, 8'h20});
        bus_stop();

        // R2 stop in the middle of an address byte
        ten_bit_mode = 1'b0;
        bus_start();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        chk("R2 stop mid address", diag_state, 8'h00);

        // R1 disable while driving ack
        bus_start();
        send_byte(8'h4A);
        chk("R1 pre-disable ack", {sda_pull_low, diag_state}, {1'b1, 8'hA8});
        enable = 1'b0;
        wclk(2);
        chk("R1 disabled idle", {sda_pull_low, diag_state}, {1'b0, 8'h00});
        enable = 1'b1;
        bus_stop();
        chk("R1 idle after reenable", diag_state, 8'h00);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule